// File: doc/BRIEF.md
# Lazy Condition-Flag Evaluator

This block rebuilds integer status flags only when a consumer needs them. Flag-setting instructions do not produce flags directly. They leave a four-word record: an operation code, two dependent words (`dep1_i`, `dep2_i`) and one auxiliary word (`ndep_i`). What each word means depends on the operation. A word can be a source operand, the result, the result shifted one place less, the result plus a carry folded in by XOR, or an earlier flag word passed through. From that record the evaluator returns the packed carry/parity/adjust/zero/sign/overflow word, a separate carry output, and whether a selected branch condition holds.

The unit is purely combinational and holds no flag state. A front end keeps the record in ordinary state and presents it, together with a 5-bit condition selector, whenever a branch, a conditional move or an explicit flag read needs the answer. Arithmetic, logic, increment/decrement, shift, rotate and multiply records are evaluated at 8, 16, 32 and 64 bits. Four bit-manipulation forms are evaluated at 32 and 64 bits. A code outside the defined range is flagged as an error.

Top module: `lazy_flag_eval`

## Requirements
- R1: The flag word places C at bit 0, P at bit 2, A at bit 4, Z at bit 6, S at bit 7 and O at bit 11; every other bit of `flags_o` is 0. Z, S and P come from the low 8/16/32/64 bits selected by the code's width. P is 1 when the low byte holds an even number of ones.
- R2: Code 0 returns `dep1_i` masked to the six flag positions.
- R3: Codes 1..52 form groups of four in width order 8, 16, 32, 64: add 1, sub 5, add-with-carry 9, sub-with-borrow 13, logic 17, increment 21, decrement 25, shift-left 29, shift-right 33, rotate-left 37, rotate-right 41, unsigned multiply 45, signed multiply 49. Codes 53..60 are 32/64-bit pairs: and-not 53, isolate-lowest-set 55, mask-up-to-lowest-set 57, reset-lowest-set 59. Any code above 60 gives an all-zero flag word and raises `op_err_o`; codes 0..60 keep `op_err_o` low.
- R4: Add and subtract take `dep1_i` and `dep2_i` as operands. C is the carry out of, or the borrow into, the selected width. A is bit 4 of left XOR right XOR result. O is the signed overflow of the selected width.
- R5: For add-with-carry and sub-with-borrow, the old carry is `ndep_i` bit 0 and the true right operand is `dep2_i` XOR `ndep_i`. The old carry is included in the sum or difference and in the carry/borrow out.
- R6: Logic and and-not take the result from `dep1_i` and clear C, O and A. And-not also forces P to 0.
- R7: Increment and decrement take the result from `dep1_i` and copy `ndep_i` bit 0 to C. A is set when the low nibble wrapped (0 after increment, F after decrement). O is set when the result is the most negative value (increment) or the most positive value (decrement).
- R8: Shifts take the result from `dep1_i` and the value shifted one place less from `dep2_i`. C is the top bit (left shift) or bit 0 (right shift) of `dep2_i`. O is the top-bit difference between the two words. A is 0.
- R9: Rotates take the result from `dep1_i`. S, Z, A and P are copied from `ndep_i`. C is result bit 0 (left) or the top bit (right). O is the top bit XOR bit 0 (left) or the top bit XOR the next bit down (right).
- R10: Multiplies set both C and O when the full product does not fit the operand width, read as unsigned or signed. Z, S and P come from the low product bits, and A is 0.
- R11: The three lowest-set-bit forms take the result from `dep1_i` and the source from `dep2_i`. C is source≠0 for isolate, and source=0 for mask and reset. O, A and P are 0.
- R12: Condition codes 0..15 test O, C, Z, C|Z, S, P, S^O and (S^O)|Z in pairs. The even code of each pair is the test itself and the odd code is its inverse.
- R13: Condition code 16 is always true; codes 17..31 are always false.
- R14: `carry_o` always equals bit 0 of `flags_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 8 | Operation code of the recorded flag-setting operation |
| dep1_i | input | 64 | First dependent word of the record |
| dep2_i | input | 64 | Second dependent word of the record |
| ndep_i | input | 64 | Auxiliary word (old carry or old flags) |
| cond_i | input | 5 | Condition selector |
| flags_o | output | 64 | Rebuilt flag word |
| carry_o | output | 1 | Carry flag alone |
| cond_true_o | output | 1 | Selected condition holds |
| op_err_o | output | 1 | Operation code out of range |

## Verification
The unit holds no state, so a wrong internal value appears at the ports in the same evaluation as the stimulus. A decode mistake puts a word in the wrong role or at the wrong width. It shows as a wrong C or O, or as Z/S/P taken from the wrong bits. Records are therefore chosen with the upper bits of each word set to non-zero values, and with carries and overflows that only a width-correct path produces. A wrong flag packing or condition table shows through `cond_true_o` during a sweep of all codes over known flag words.

// File: rtl/lfe_pkg.sv
package lfe_pkg;

  localparam int WORD_W = 64;
  localparam int BIT_C  = 0;
  localparam int BIT_P  = 2;
  localparam int BIT_A  = 4;
  localparam int BIT_Z  = 6;
  localparam int BIT_S  = 7;
  localparam int BIT_O  = 11;
  localparam int OP_W   = 8;
  localparam int CC_W   = 5;
  localparam int LAST_OP = 60;

  typedef enum logic [4:0] {
    G_COPY   = 5'd0,
    G_ADD    = 5'd1,
    G_SUB    = 5'd2,
    G_ADC    = 5'd3,
    G_SBB    = 5'd4,
    G_LOGIC  = 5'd5,
    G_INC    = 5'd6,
    G_DEC    = 5'd7,
    G_SHL    = 5'd8,
    G_SHR    = 5'd9,
    G_ROL    = 5'd10,
    G_ROR    = 5'd11,
    G_UMUL   = 5'd12,
    G_SMUL   = 5'd13,
    G_ANDN   = 5'd14,
    G_BLSI   = 5'd15,
    G_BLSMSK = 5'd16,
    G_BLSR   = 5'd17,
    G_BAD    = 5'd31
  } lfe_grp_e;

  typedef enum logic [1:0] {SZ8 = 2'd0, SZ16 = 2'd1, SZ32 = 2'd2, SZ64 = 2'd3} lfe_sz_e;

  typedef struct packed {
    logic o;
    logic s;
    logic z;
    logic a;
    logic p;
    logic c;
  } lfe_flags_t;

  function automatic logic [WORD_W-1:0] sz_mask(lfe_sz_e s);
    case (s)
      SZ8:     return 64'h0000_0000_0000_00FF;
      SZ16:    return 64'h0000_0000_0000_FFFF;
      SZ32:    return 64'h0000_0000_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] top_bit(lfe_sz_e s);
    return sz_mask(s) ^ (sz_mask(s) >> 1);
  endfunction

  function automatic logic msb_of(logic [WORD_W-1:0] x, lfe_sz_e s);
    return |(x & top_bit(s));
  endfunction

  function automatic logic next_msb_of(logic [WORD_W-1:0] x, lfe_sz_e s);
    return |(x & (top_bit(s) >> 1));
  endfunction

  function automatic logic even_par(logic [7:0] b);
    return ~(^b);
  endfunction

endpackage

// File: rtl/lfe_op_decode.sv
module lfe_op_decode
  import lfe_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output lfe_grp_e        grp_o,
  output lfe_sz_e         sz_o
);

  logic [2:0] pair_idx;

  always_comb begin
    pair_idx = 3'(op_i - OP_W'(53));
    grp_o    = G_BAD;
    sz_o     = SZ64;
    if (op_i == '0) begin
      grp_o = G_COPY;
    end else if (op_i <= OP_W'(52)) begin
      grp_o = lfe_grp_e'(5'((op_i - OP_W'(1)) >> 2) + 5'd1);
      sz_o  = lfe_sz_e'(2'(op_i - OP_W'(1)));
    end else if (op_i <= OP_W'(LAST_OP)) begin
      grp_o = lfe_grp_e'(5'(G_ANDN) + {3'b000, pair_idx[2:1]});
      sz_o  = pair_idx[0] ? SZ64 : SZ32;
    end
  end

endmodule

// File: rtl/lfe_mul_fit.sv
module lfe_mul_fit
  import lfe_pkg::*;
#(
  parameter int DW = WORD_W
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  lfe_sz_e       sz_i,
  input  logic          signed_i,
  output logic [DW-1:0] lo_o,
  output logic          ovf_o
);

  localparam int PW = 2 * DW;

  logic [PW-1:0] a_ext, b_ext, prod, lo_ext, keep_mask;
  logic [DW-1:0] m;

  function automatic logic [PW-1:0] widen(logic [DW-1:0] x, lfe_sz_e s, logic sgn);
    logic [PW-1:0] r;
    case (s)
      SZ8:     r = {{(PW-8){sgn & x[7]}},   x[7:0]};
      SZ16:    r = {{(PW-16){sgn & x[15]}}, x[15:0]};
      SZ32:    r = {{(PW-32){sgn & x[31]}}, x[31:0]};
      default: r = {{(PW-DW){sgn & x[DW-1]}}, x};
    endcase
    return r;
  endfunction

  always_comb begin
    m         = sz_mask(sz_i);
    a_ext     = widen(a_i, sz_i, signed_i);
    b_ext     = widen(b_i, sz_i, signed_i);
    prod      = a_ext * b_ext;
    lo_o      = prod[DW-1:0];
    lo_ext    = widen(prod[DW-1:0], sz_i, signed_i);
    keep_mask = {{(PW-DW){1'b0}}, m};
    if (signed_i) ovf_o = (prod != lo_ext);
    else          ovf_o = |(prod & ~keep_mask);
  end

endmodule

// File: rtl/lfe_flag_core.sv
module lfe_flag_core
  import lfe_pkg::*;
(
  input  lfe_grp_e          grp_i,
  input  lfe_sz_e           sz_i,
  input  logic [WORD_W-1:0] dep1_i,
  input  logic [WORD_W-1:0] dep2_i,
  input  logic [WORD_W-1:0] ndep_i,
  output lfe_flags_t        fl_o
);

  logic [WORD_W-1:0] m, lhs, rhs, res, mul_lo;
  logic              old_c, mul_ovf, use_szp, use_par;

  lfe_mul_fit #(.DW(WORD_W)) u_mul (
    .a_i      (dep1_i),
    .b_i      (dep2_i),
    .sz_i     (sz_i),
    .signed_i (grp_i == G_SMUL),
    .lo_o     (mul_lo),
    .ovf_o    (mul_ovf)
  );

  always_comb begin
    m       = sz_mask(sz_i);
    old_c   = ndep_i[0];
    lhs     = dep1_i;
    rhs     = dep2_i;
    res     = dep1_i;
    fl_o    = '0;
    use_szp = 1'b1;
    use_par = 1'b1;
    case (grp_i)
      G_COPY: begin
        use_szp = 1'b0;
        fl_o.c = dep1_i[BIT_C];
        fl_o.p = dep1_i[BIT_P];
        fl_o.a = dep1_i[BIT_A];
        fl_o.z = dep1_i[BIT_Z];
        fl_o.s = dep1_i[BIT_S];
        fl_o.o = dep1_i[BIT_O];
      end
      G_ADD, G_ADC: begin
        if (grp_i == G_ADC) rhs = dep2_i ^ ndep_i;
        res = lhs + rhs + ((grp_i == G_ADC) ? {{(WORD_W-1){1'b0}}, old_c} : '0);
        if (grp_i == G_ADC && old_c) fl_o.c = (res & m) <= (lhs & m);
        else                         fl_o.c = (res & m) <  (lhs & m);
        fl_o.a = lhs[BIT_A] ^ rhs[BIT_A] ^ res[BIT_A];
        fl_o.o = msb_of(~(lhs ^ rhs) & (lhs ^ res), sz_i);
      end
      G_SUB, G_SBB: begin
        if (grp_i == G_SBB) rhs = dep2_i ^ ndep_i;
        res = lhs - rhs - ((grp_i == G_SBB) ? {{(WORD_W-1){1'b0}}, old_c} : '0);
        if (grp_i == G_SBB && old_c) fl_o.c = (lhs & m) <= (rhs & m);
        else                         fl_o.c = (lhs & m) <  (rhs & m);
        fl_o.a = lhs[BIT_A] ^ rhs[BIT_A] ^ res[BIT_A];
        fl_o.o = msb_of((lhs ^ rhs) & (lhs ^ res), sz_i);
      end
      G_LOGIC: ;
      G_INC: begin
        fl_o.c = old_c;
        fl_o.a = (res[3:0] == 4'h0);
        fl_o.o = ((res & m) == top_bit(sz_i));
      end
      G_DEC: begin
        fl_o.c = old_c;
        fl_o.a = (res[3:0] == 4'hF);
        fl_o.o = ((res & m) == (m >> 1));
      end
      G_SHL: begin
        fl_o.c = msb_of(dep2_i, sz_i);
        fl_o.o = msb_of(dep1_i ^ dep2_i, sz_i);
      end
      G_SHR: begin
        fl_o.c = dep2_i[0];
        fl_o.o = msb_of(dep1_i ^ dep2_i, sz_i);
      end
      G_ROL, G_ROR: begin
        use_szp = 1'b0;
        fl_o.s  = ndep_i[BIT_S];
        fl_o.z  = ndep_i[BIT_Z];
        fl_o.a  = ndep_i[BIT_A];
        fl_o.p  = ndep_i[BIT_P];
        if (grp_i == G_ROL) begin
          fl_o.c = res[0];
          fl_o.o = msb_of(res, sz_i) ^ res[0];
        end else begin
          fl_o.c = msb_of(res, sz_i);
          fl_o.o = msb_of(res, sz_i) ^ next_msb_of(res, sz_i);
        end
      end
      G_UMUL, G_SMUL: begin
        res    = mul_lo;
        fl_o.c = mul_ovf;
        fl_o.o = mul_ovf;
      end
      G_ANDN:   use_par = 1'b0;
      G_BLSI: begin
        use_par = 1'b0;
        fl_o.c  = (dep2_i & m) != '0;
      end
      G_BLSMSK, G_BLSR: begin
        use_par = 1'b0;
        fl_o.c  = (dep2_i & m) == '0;
      end
      default: use_szp = 1'b0;
    endcase
    if (use_szp) begin
      fl_o.z = (res & m) == '0;
      fl_o.s = msb_of(res, sz_i);
      fl_o.p = use_par ? even_par(res[7:0]) : 1'b0;
    end
  end

endmodule

// File: rtl/lfe_cond_eval.sv
module lfe_cond_eval
  import lfe_pkg::*;
(
  input  lfe_flags_t      fl_i,
  input  logic [CC_W-1:0] code_i,
  output logic            hold_o
);

  logic base;

  always_comb begin
    case (code_i[3:1])
      3'd0: base = fl_i.o;
      3'd1: base = fl_i.c;
      3'd2: base = fl_i.z;
      3'd3: base = fl_i.c | fl_i.z;
      3'd4: base = fl_i.s;
      3'd5: base = fl_i.p;
      3'd6: base = fl_i.s ^ fl_i.o;
      default: base = (fl_i.s ^ fl_i.o) | fl_i.z;
    endcase
    if (code_i[CC_W-1]) hold_o = (code_i[CC_W-2:0] == '0);
    else                hold_o = base ^ code_i[0];
  end

endmodule

// File: rtl/lazy_flag_eval.sv
module lazy_flag_eval
  import lfe_pkg::*;
(
  input  logic [7:0]  op_i,
  input  logic [63:0] dep1_i,
  input  logic [63:0] dep2_i,
  input  logic [63:0] ndep_i,
  input  logic [4:0]  cond_i,
  output logic [63:0] flags_o,
  output logic        carry_o,
  output logic        cond_true_o,
  output logic        op_err_o
);

  lfe_grp_e   grp;
  lfe_sz_e    sz;
  lfe_flags_t fl;

  lfe_op_decode u_dec (
    .op_i  (op_i),
    .grp_o (grp),
    .sz_o  (sz)
  );

  lfe_flag_core u_core (
    .grp_i  (grp),
    .sz_i   (sz),
    .dep1_i (dep1_i),
    .dep2_i (dep2_i),
    .ndep_i (ndep_i),
    .fl_o   (fl)
  );

  lfe_cond_eval u_cond (
    .fl_i   (fl),
    .code_i (cond_i),
    .hold_o (cond_true_o)
  );

  always_comb begin
    flags_o        = '0;
    flags_o[BIT_C] = fl.c;
    flags_o[BIT_P] = fl.p;
    flags_o[BIT_A] = fl.a;
    flags_o[BIT_Z] = fl.z;
    flags_o[BIT_S] = fl.s;
    flags_o[BIT_O] = fl.o;
    carry_o        = fl.c;
    op_err_o       = (grp == G_BAD);
  end

endmodule

// File: rtl/lazy_flag_eval_chk.sv
module lazy_flag_eval_chk (
  input logic [7:0]  op_i,
  input logic [63:0] dep1_i,
  input logic [63:0] ndep_i,
  input logic [4:0]  cond_i,
  input logic [63:0] flags_o,
  input logic        carry_o,
  input logic        cond_true_o,
  input logic        op_err_o
);

  localparam logic [63:0] FLAG_SET = 64'h0000_0000_0000_08D5;
  localparam logic [63:0] ROT_KEEP = 64'h0000_0000_0000_00D4;

  always_comb begin
    p_unused_bits_zero_r1: assert ((flags_o & ~FLAG_SET) == '0)
      else $error("flag word has bits outside the six flag positions");
    p_copy_mask_r2: assert (op_i != 8'd0 || flags_o == (dep1_i & FLAG_SET))
      else $error("copy code did not return masked dep1");
    p_bad_op_zero_r3: assert ((op_i > 8'd60) == op_err_o && (!op_err_o || flags_o == '0))
      else $error("out-of-range code handling wrong");
    p_logic_clear_r6: assert (!(op_i >= 8'd17 && op_i <= 8'd20) || (flags_o & 64'h811) == '0)
      else $error("logic code left C, A or O set");
    p_rot_keeps_r9: assert (!(op_i >= 8'd37 && op_i <= 8'd44) || (flags_o & ROT_KEEP) == (ndep_i & ROT_KEEP))
      else $error("rotate altered S, Z, A or P");
    p_cond_fixed_r13: assert (!cond_i[4] || cond_true_o == (cond_i == 5'd16))
      else $error("fixed condition codes wrong");
    p_carry_output_r14: assert (carry_o == flags_o[0])
      else $error("carry output differs from flag word bit 0");
  end

endmodule

bind lazy_flag_eval lazy_flag_eval_chk chk_i (
  .op_i        (op_i),
  .dep1_i      (dep1_i),
  .ndep_i      (ndep_i),
  .cond_i      (cond_i),
  .flags_o     (flags_o),
  .carry_o     (carry_o),
  .cond_true_o (cond_true_o),
  .op_err_o    (op_err_o)
);

// File: tb/lazy_flag_eval_tb_top.sv
module lazy_flag_eval_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int WDOG_CYC = 20000;

  logic        clk;
  logic        rst_n;
  logic [7:0]  op;
  logic [63:0] d1, d2, nd;
  logic [4:0]  cc;
  logic [63:0] flags;
  logic        carry, ctrue, err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  lazy_flag_eval dut_i (
    .op_i        (op),
    .dep1_i      (d1),
    .dep2_i      (d2),
    .ndep_i      (nd),
    .cond_i      (cc),
    .flags_o     (flags),
    .carry_o     (carry),
    .cond_true_o (ctrue),
    .op_err_o    (err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [7:0] o, logic [63:0] a, logic [63:0] b, logic [63:0] n, logic [4:0] c);
    @(negedge clk);
    op = o; d1 = a; d2 = b; nd = n; cc = c;
    @(posedge clk);
    #1;
  endtask

  task automatic run_op(string tag, logic [7:0] o, logic [63:0] a, logic [63:0] b,
                        logic [63:0] n, logic [63:0] expf);
    drive(o, a, b, n, 5'd16);
    chk(tag, flags, expf);
    chk({tag, " R14 carry"}, {63'b0, carry}, {63'b0, expf[0]});
    chk({tag, " R3 no error"}, {63'b0, err}, 64'd0);
  endtask

  task automatic t_idle();
    chk("R2 idle flags", flags, 64'd0);
    chk("R12 idle cond O", {63'b0, ctrue}, 64'd0);
    chk("R3 idle error", {63'b0, err}, 64'd0);
  endtask

  task automatic t_copy();
    run_op("R2 copy all ones", 8'd0, '1, 64'h1234, 64'h0, 64'h8D5);
    run_op("R2 copy sparse", 8'd0, 64'hF000_0000_0000_0201, 64'h0, 64'h0, 64'h1);
  endtask

  task automatic t_add_sub();
    run_op("R4 add8 overflow", 8'd1, 64'hAB00_0000_0000_007F, 64'h1, 64'h0, 64'h890);
    run_op("R4 add16 carry", 8'd2, 64'hFFFF, 64'h1, 64'h0, 64'h55);
    run_op("R4 sub32 borrow", 8'd7, 64'h5, 64'h7, 64'h0, 64'h91);
    run_op("R4 sub64 overflow", 8'd8, 64'h8000_0000_0000_0000, 64'h1, 64'h0, 64'h814);
  endtask

  task automatic t_carry_chain();
    run_op("R5 adc8 carry in", 8'd9, 64'hFF, 64'h1, 64'h1, 64'h55);
    run_op("R5 sbb16 borrow in", 8'd14, 64'h5, 64'h4, 64'h1, 64'h95);
    run_op("R5 adc8 no carry in", 8'd9, 64'hFF, 64'h0, 64'h0, 64'h84);
  endtask

  task automatic t_logic_incdec();
    run_op("R6 logic32 zero", 8'd19, 64'hFFFF_FFFF_0000_0000, 64'h0, 64'h1, 64'h44);
    run_op("R6 andn32 sign", 8'd53, 64'h8000_0000, 64'h0, 64'h0, 64'h80);
    run_op("R7 inc8 wrap", 8'd21, 64'h80, 64'h0, 64'h1, 64'h891);
    run_op("R7 dec16 wrap", 8'd26, 64'h7FFF, 64'h0, 64'h0, 64'h814);
  endtask

  task automatic t_shift_rot();
    run_op("R8 shl8", 8'd29, 64'h82, 64'hC1, 64'h0, 64'h85);
    run_op("R8 shr32", 8'd35, 64'h4000_0000, 64'h8000_0000, 64'h0, 64'h804);
    run_op("R9 rol16", 8'd38, 64'h8001, 64'h0, 64'h8D5, 64'hD5);
    run_op("R9 ror64", 8'd44, 64'h8000_0000_0000_0000, 64'h0, 64'h0, 64'h801);
  endtask

  task automatic t_mul();
    run_op("R10 umul8 overflow", 8'd45, 64'h10, 64'h10, 64'h0, 64'h845);
    run_op("R10 umul16 fits", 8'd46, 64'hFF, 64'h2, 64'h0, 64'h0);
    run_op("R10 umul64 overflow", 8'd48, '1, 64'h2, 64'h0, 64'h881);
    run_op("R10 smul8 overflow", 8'd49, 64'hFF, 64'h80, 64'h0, 64'h881);
    run_op("R10 smul64 fits", 8'd52, 64'hFFFF_FFFF_FFFF_FFFE, 64'h3, 64'h0, 64'h84);
  endtask

  task automatic t_bitmanip();
    run_op("R11 blsi64", 8'd56, 64'h4, 64'hC, 64'h0, 64'h1);
    run_op("R11 blsi32 zero src", 8'd55, 64'h0, 64'h0, 64'h0, 64'h40);
    run_op("R11 blsmsk32 zero src", 8'd57, 64'hFFFF_FFFF, 64'h0, 64'h0, 64'h81);
    run_op("R11 blsr64 one", 8'd60, 64'h0, 64'h1, 64'h0, 64'h40);
    run_op("R11 blsr64 zero src", 8'd60, 64'h0, 64'h0, 64'h0, 64'h41);
  endtask

  task automatic t_bad_op();
    drive(8'd61, '1, '1, '1, 5'd16);
    chk("R3 code 61 flags", flags, 64'd0);
    chk("R3 code 61 error", {63'b0, err}, 64'd1);
    chk("R14 code 61 carry", {63'b0, carry}, 64'd0);
    drive(8'd255, '1, '1, '1, 5'd16);
    chk("R3 code 255 flags", flags, 64'd0);
    chk("R3 code 255 error", {63'b0, err}, 64'd1);
  endtask

  task automatic cond_sweep(string tag, logic [63:0] fw, logic [15:0] expv);
    for (int k = 0; k < 16; k++) begin
      drive(8'd0, fw, 64'h0, 64'h0, 5'(k));
      chk($sformatf("%s code %0d", tag, k), {63'b0, ctrue}, {63'b0, expv[k]});
    end
  endtask

  task automatic t_cond();
    cond_sweep("R12 O+Z+C", 64'h841, 16'h5A55);
    cond_sweep("R12 S+P", 64'h084, 16'h55AA);
    drive(8'd0, 64'h0, 64'h0, 64'h0, 5'd16);
    chk("R13 code 16", {63'b0, ctrue}, 64'd1);
    drive(8'd0, 64'h8D5, 64'h0, 64'h0, 5'd17);
    chk("R13 code 17", {63'b0, ctrue}, 64'd0);
    drive(8'd0, 64'h8D5, 64'h0, 64'h0, 5'd31);
    chk("R13 code 31", {63'b0, ctrue}, 64'd0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0;
    op = '0; d1 = '0; d2 = '0; nd = '0; cc = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_idle();
    t_copy();
    t_add_sub();
    t_carry_chain();
    t_logic_incdec();
    t_shift_rot();
    t_mul();
    t_bitmanip();
    t_bad_op();
    t_cond();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

endmodule